// File: doc/BRIEF.md
# Execute Stage: Operand Steering, ALU, Flag Register and Condition Test

This block is the arithmetic step of a single-cycle processor datapath. For each instruction it chooses the two operands of the ALU from the register read values, the immediate constant of the instruction, or fixed stack-step constants. It then computes the result word that later steps use as a memory address, a stack pointer update or a register write value.

The block also holds a two-bit flag register: a zero flag and a sign flag. Only the arithmetic/logic instruction class writes it, at the clock edge that ends that instruction. Conditional branches and conditional moves select one of seven conditions with their function code. They get back a single take bit, which is derived from the flags left by an earlier instruction.

The block is combinational from the instruction fields to the result and the take bit. The only state it holds is the flag register. Reset is asynchronous active-low and is released to the flag register through a two-stage synchronizer.

Top module: `exec_unit`

## Requirements
- R1: With opcode 6 (arithmetic class), function code 0 gives src_b + src_a, 1 gives src_b - src_a, 2 gives src_b AND src_a, and 3 gives src_b XOR src_a, all modulo 2^W.
- R2: Opcodes 4 (store) and 5 (load) give result = src_b + imm.
- R3: Opcodes 8 (call) and 10 (push) give result = src_b - 8. Opcodes 9 (return) and 11 (pop) give result = src_b + 8.
- R4: Opcode 2 (register move / conditional move) gives result = src_a, and opcode 3 (immediate load) gives result = imm.
- R5: Opcodes 0, 1, 7 and 12 to 15 give result = 0.
- R6: After reset the zero flag is 1 and the sign flag is 0. An opcode-6 instruction writes zero = (result == 0) and sign = result[W-1] at its closing clock edge. The new flags are visible through take from the following cycle.
- R7: Every opcode other than 6 leaves both flags unchanged, whatever its operands and result.
- R8: For opcodes 2 and 7, take equals the condition chosen by the function code, using Z and S for the stored flags: 0 always → 1, 1 → S OR Z, 2 → S, 3 → Z, 4 → NOT Z, 5 → NOT S, 6 → NOT S AND NOT Z. Function codes 7 to 15 give 0.
- R9: For every opcode other than 2 and 7, take is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 4 | Instruction class code |
| fn_code | input | 4 | Function code: ALU operation or condition select |
| src_a | input | W | First register read value |
| src_b | input | W | Second register read value (stack pointer for stack operations) |
| imm | input | W | Immediate constant or displacement of the instruction |
| result | output | W | ALU result |
| take | output | 1 | Condition outcome for conditional branch/move |

## Verification
The assertions assume that op_code and fn_code are always known values. They also assume that an opcode-6 instruction carries a function code from 0 to 3. They take the internally synchronized reset as their disable, so they make no claim during the two cycles after rst_n rises. The stimulus restricts arithmetic function codes to 0 through 3 and keeps the opcode at a no-op for several cycles after reset release. It steps every function code 0 to 15 only on the conditional opcodes, where all sixteen values are defined.

// File: rtl/exe_pkg.sv
`timescale 1ns/1ps
package exe_pkg;
  localparam int OPC_W = 4;
  localparam int FN_W  = 4;
  localparam int NUM_CONDS = 7;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OP_NOP   = 4'h1;
  localparam logic [OPC_W-1:0] OP_MOVE  = 4'h2;
  localparam logic [OPC_W-1:0] OP_LOADC = 4'h3;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h4;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [OPC_W-1:0] OP_ARITH = 4'h6;
  localparam logic [OPC_W-1:0] OP_BRCH  = 4'h7;
  localparam logic [OPC_W-1:0] OP_CALL  = 4'h8;
  localparam logic [OPC_W-1:0] OP_RET   = 4'h9;
  localparam logic [OPC_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [OPC_W-1:0] OP_POP   = 4'hB;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;
endpackage

// File: rtl/exe_rst_sync.sv
`timescale 1ns/1ps
module exe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/exe_operand_sel.sv
`timescale 1ns/1ps
module exe_operand_sel
  import exe_pkg::*;
#(
  parameter int W = 64,
  parameter int STACK_STEP = 8
) (
  input  logic [OPC_W-1:0] op_code,
  input  logic [1:0]       fn_low,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [W-1:0]     imm,
  output logic [W-1:0]     opnd_a,
  output logic [W-1:0]     opnd_b,
  output alu_fn_e          alu_fn,
  output logic             cc_we
);
  localparam logic [W-1:0] STEP_UP   = W'(STACK_STEP);
  localparam logic [W-1:0] STEP_DOWN = '0 - W'(STACK_STEP);

  always_comb begin
    opnd_a = '0;
    opnd_b = '0;
    alu_fn = FN_ADD;
    cc_we  = 1'b0;
    case (op_code)
      OP_MOVE:  opnd_a = src_a;
      OP_LOADC: opnd_a = imm;
      OP_STORE, OP_LOAD: begin
        opnd_a = imm;
        opnd_b = src_b;
      end
      OP_ARITH: begin
        opnd_a = src_a;
        opnd_b = src_b;
        alu_fn = alu_fn_e'(fn_low);
        cc_we  = 1'b1;
      end
      OP_CALL, OP_PUSH: begin
        opnd_a = STEP_DOWN;
        opnd_b = src_b;
      end
      OP_RET, OP_POP: begin
        opnd_a = STEP_UP;
        opnd_b = src_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exe_alu.sv
`timescale 1ns/1ps
module exe_alu
  import exe_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_fn_e      alu_fn,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res,
  output logic         res_zero,
  output logic         res_neg
);
  always_comb begin
    case (alu_fn)
      FN_ADD:  res = opnd_b + opnd_a;
      FN_SUB:  res = opnd_b - opnd_a;
      FN_AND:  res = opnd_b & opnd_a;
      FN_XOR:  res = opnd_b ^ opnd_a;
      default: res = '0;
    endcase
  end

  assign res_zero = (res == '0);
  assign res_neg  = res[W-1];
endmodule

// File: rtl/exe_flag_cond.sv
`timescale 1ns/1ps
module exe_flag_cond
  import exe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cc_we,
  input  logic             zero_in,
  input  logic             neg_in,
  input  logic [OPC_W-1:0] op_code,
  input  logic [FN_W-1:0]  fn_code,
  output logic             take,
  output logic             flag_z,
  output logic             flag_s
);
  localparam int TAB_N = 1 << FN_W;

  logic zf_q, sf_q, zf_d, sf_d;
  logic [TAB_N-1:0] cond_tab;
  logic is_cond_op;

  always_comb begin
    zf_d = zero_in;
    sf_d = neg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q <= 1'b1;
      sf_q <= 1'b0;
    end else if (cc_we) begin
      zf_q <= zf_d;
      sf_q <= sf_d;
    end
  end

  assign cond_tab[0] = 1'b1;
  assign cond_tab[1] = sf_q | zf_q;
  assign cond_tab[2] = sf_q;
  assign cond_tab[3] = zf_q;
  assign cond_tab[4] = ~zf_q;
  assign cond_tab[5] = ~sf_q;
  assign cond_tab[6] = ~sf_q & ~zf_q;

  generate
    for (genvar k = NUM_CONDS; k < TAB_N; k++) begin : g_undef_cond
      assign cond_tab[k] = 1'b0;
    end
  endgenerate

  assign is_cond_op = (op_code == OP_MOVE) || (op_code == OP_BRCH);
  assign take   = is_cond_op & cond_tab[fn_code];
  assign flag_z = zf_q;
  assign flag_s = sf_q;
endmodule

// File: rtl/exec_unit.sv
`timescale 1ns/1ps
module exec_unit
  import exe_pkg::*;
#(
  parameter int W = 64,
  parameter int STACK_STEP = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op_code,
  input  logic [FN_W-1:0]  fn_code,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [W-1:0]     imm,
  output logic [W-1:0]     result,
  output logic             take
);
  logic         rst_sync_n;
  logic [W-1:0] opnd_a, opnd_b;
  alu_fn_e      alu_fn;
  logic         cc_we, res_zero, res_neg;
  logic         flag_z, flag_s;

  exe_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  exe_operand_sel #(.W(W), .STACK_STEP(STACK_STEP)) i_opsel (
    .op_code(op_code), .fn_low(fn_code[1:0]),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_fn(alu_fn), .cc_we(cc_we)
  );

  exe_alu #(.W(W)) i_alu (
    .alu_fn(alu_fn), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res(result), .res_zero(res_zero), .res_neg(res_neg)
  );

  exe_flag_cond i_flags (
    .clk(clk), .rst_n(rst_sync_n), .cc_we(cc_we),
    .zero_in(res_zero), .neg_in(res_neg),
    .op_code(op_code), .fn_code(fn_code),
    .take(take), .flag_z(flag_z), .flag_s(flag_s)
  );
endmodule

// File: rtl/exec_unit_chk.sv
`timescale 1ns/1ps
module exec_unit_chk
  import exe_pkg::*;
#(
  parameter int W = 64,
  parameter int STACK_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] op_code,
  input logic [FN_W-1:0]  fn_code,
  input logic [W-1:0]     src_b,
  input logic [W-1:0]     result,
  input logic             take,
  input logic             flag_z,
  input logic             flag_s
);
  logic cond_op;
  assign cond_op = (op_code == OP_MOVE) || (op_code == OP_BRCH);

  assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != OP_ARITH) |=> ($stable(flag_z) && $stable(flag_s)));

  assert_cc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_ARITH) |=>
      ((flag_z == ($past(result) == '0)) && (flag_s == $past(result[W-1]))));

  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_PUSH || op_code == OP_CALL) |-> (result == src_b - W'(STACK_STEP)));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_POP || op_code == OP_RET) |-> (result == src_b + W'(STACK_STEP)));

  assert_cond_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_op && fn_code == 4'd0) |-> take);

  assert_cond_le_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_op && fn_code == 4'd1) |-> (take == (flag_s | flag_z)));

  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond_op) |-> !take);
endmodule

bind exec_unit exec_unit_chk #(.W(W), .STACK_STEP(STACK_STEP)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_code(op_code), .fn_code(fn_code),
  .src_b(src_b), .result(result), .take(take),
  .flag_z(flag_z), .flag_s(flag_s)
);

// File: tb/test_exec_unit.sv
`timescale 1ns/1ps
module test_exec_unit;
  localparam int W = 8;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op_code = 4'h1;
  logic [3:0] fn_code = 4'h0;
  logic [W-1:0] src_a = '0, src_b = '0, imm = '0;
  logic [W-1:0] result;
  logic take;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit ez, es;

  always #10 clk = ~clk;

  exec_unit #(.W(W)) i_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .fn_code(fn_code),
    .src_a(src_a), .src_b(src_b), .imm(imm), .result(result), .take(take)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0h fn=%0h a=%0h b=%0h c=%0h: actual %0h expected %0h",
               req, op_code, fn_code, src_a, src_b, imm, act, exp);
    end
  endtask

  function automatic bit cond_exp(input logic [3:0] f, input bit z, input bit s);
    case (f)
      4'd0: return 1'b1;
      4'd1: return s | z;
      4'd2: return s;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !s;
      4'd6: return !s && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] vale_exp(input logic [3:0] op, input logic [3:0] f,
                                            input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] c);
    case (op)
      4'h2: return a;
      4'h3: return c;
      4'h4, 4'h5: return W'(b + c);
      4'h6: case (f[1:0])
              2'd0: return W'(b + a);
              2'd1: return W'(b - a);
              2'd2: return b & a;
              default: return b ^ a;
            endcase
      4'h8, 4'hA: return W'(b - 8);
      4'h9, 4'hB: return W'(b + 8);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h2, 4'h3: return "R4";
      4'h4, 4'h5: return "R2";
      4'h6: return "R1";
      4'h8, 4'h9, 4'hA, 4'hB: return "R3";
      default: return "R5";
    endcase
  endfunction

  // Called just after a falling edge: steps all function codes on the
  // conditional opcodes within the low phase, no rising edge in between.
  task automatic sweep_take(input string req);
    for (int f = 0; f < 16; f++) begin
      op_code = (f % 2 == 1) ? 4'h7 : 4'h2;
      fn_code = 4'(f);
      #0.5;
      check(req, W'(take), W'(cond_exp(4'(f), ez, es)));
    end
    op_code = 4'h1;
    fn_code = 4'h0;
  endtask

  // One arithmetic instruction, then the next cycle inspects the flags.
  task automatic run_arith(input logic [1:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] e;
    @(negedge clk);
    op_code = 4'h6; fn_code = {2'b00, f}; src_a = a; src_b = b;
    e = vale_exp(4'h6, {2'b00, f}, a, b, '0);
    #5;
    check("R1", result, e);
    check("R9", W'(take), '0);
    ez = (e == '0);
    es = e[W-1];
    @(negedge clk);
    sweep_take("R6 R8");
  endtask

  initial begin
    logic [W-1:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hF8, 8'hFF};
    int k;
    // Reset state (R5 result with no-op, R6 flags after reset).
    repeat (3) @(posedge clk);
    #1;
    check("R5", result, '0);
    check("R9", W'(take), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ez = 1'b1; es = 1'b0;
    sweep_take("R6");

    // R1/R6/R8: arithmetic sweep with flag readback.
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 7)
          run_arith(2'(f), W'(a), W'(b));
    // Boundary vectors: zero, sign bit, wraparound.
    run_arith(2'd1, 8'h01, 8'h00);
    run_arith(2'd0, 8'h01, 8'hFF);
    run_arith(2'd0, 8'h00, 8'h80);
    run_arith(2'd3, 8'h5A, 8'h5A);
    run_arith(2'd2, 8'h0F, 8'hF0);

    // R2..R5, R7, R9 with two flag presets.
    k = 0;
    for (int preset = 0; preset < 2; preset++) begin
      if (preset == 0) run_arith(2'd1, 8'h01, 8'h00);
      else             run_arith(2'd3, 8'h33, 8'h33);
      for (int op = 0; op < 16; op++) begin
        if (op == 6) continue;
        for (int ia = 0; ia < 6; ia++)
          for (int ib = 0; ib < 6; ib++)
            for (int ic = 0; ic < 6; ic++) begin
              @(negedge clk);
              op_code = 4'(op); fn_code = 4'(k % 16); k++;
              src_a = vals[ia]; src_b = vals[ib]; imm = vals[ic];
              #5;
              check(req_of(4'(op)), result, vale_exp(4'(op), fn_code, src_a, src_b, imm));
              if (op == 2 || op == 7)
                check("R8", W'(take), W'(cond_exp(fn_code, ez, es)));
              else
                check("R9", W'(take), '0);
            end
        @(negedge clk);
        sweep_take("R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule